// File: doc/BRIEF.md
# Double-Buffered Timer Compare Stage

This block is the compare end of an 8-bit general-purpose timer. It keeps an active compare value and a shadow copy. Both sit behind one write port. Each cycle it compares the active value with the timer's up counter and emits a one-cycle match-detect pulse. The pulse goes to whatever waveform or interrupt logic sits downstream.

A buffer-enable input sets where a bus write goes. With buffering off, a write lands in the active and shadow registers together. With buffering on, a write lands only in the shadow. The shadow then moves into the active register on a shift trigger that depends on the mode:

- the counter's 2^n overflow pulse in PWM mode;
- the cycle-start pulse in PPG mode;
- never in plain timer mode, or in the reserved mode code.

This lets software stage the next period or duty value without disturbing the cycle in progress. The write strobe is a plain one-cycle command. The stage accepts it every cycle, so it has no back-pressure and no ready signal. The registers cannot be read back, and the only visible state is the active compare value output.

Top module: `dbuf_cmp_stage`

## Requirements
- R1: While reset is asserted, and after it is released, the active compare value is 00H, the shadow is 00H and match-detect is low.
- R2: When the active value is non-zero and equals `count` in a cycle, `match_o` is high for exactly the following cycle. Otherwise `match_o` stays low.
- R3: When the active value is 00H, `match_o` rises in the cycle after `ovf_pulse` is high. A `count` of 00H without `ovf_pulse` gives no match.
- R4: With `buf_en`=0, a write (`wr_en`=1) puts `wr_data` into both registers. The new value appears on `cmp_value_o` in the next cycle.
- R5: With `buf_en`=1, a write updates only the shadow. `cmp_value_o` keeps its value unless a shift trigger occurs.
- R6: With `buf_en`=1 and `mode`=2'b01 (PWM), an `ovf_pulse` copies the shadow into the active register.
- R7: With `buf_en`=1 and `mode`=2'b10 (PPG), a `start_pulse` copies the shadow into the active register.
- R8: In `mode`=2'b00 (timer) and in the reserved `mode`=2'b11, no shadow-to-active transfer happens, whatever the pulses.
- R9: The trigger that does not belong to the current mode causes no transfer: `start_pulse` in PWM mode, and `ovf_pulse` in PPG mode.
- R10: When a buffered write and a valid trigger fall in the same cycle, the active register takes the old shadow value and the shadow takes the new write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe for the shared compare address |
| wr_data | input | 8 | Write data |
| buf_en | input | 1 | 1 = buffered writes, 0 = direct writes |
| mode | input | 2 | 00 timer, 01 PWM, 10 PPG, 11 reserved (acts as timer) |
| count | input | 8 | Up-counter value |
| ovf_pulse | input | 1 | Counter overflow pulse (the 2^n overflow in PWM mode) |
| start_pulse | input | 1 | Cycle-start pulse (PPG mode) |
| match_o | output | 1 | Registered single-cycle match-detect pulse |
| cmp_value_o | output | 8 | Current active compare value |

## Verification
The hardest situation to reach from the ports is R10: a buffered write and a valid shift trigger in the same cycle. It only shows up when the shadow already holds a value that differs from both the active value and the new write data. The stimulus first stages a distinct value through a buffered write, then issues the write and the trigger together. It then fires one more trigger, so that the hidden shadow contents come out on `cmp_value_o`.

The shadow also cannot be seen in R5, R8 and R9. There, each ignored trigger is followed by a legitimate trigger that shows what the shadow held. A pseudo-random phase then mixes every input against the behavioural model.

// File: rtl/dbuf_cmp_pkg.sv
package dbuf_cmp_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_PWM   = 2'b01,
    MODE_PPG   = 2'b10,
    MODE_RSVD  = 2'b11
  } cmp_mode_e;
endpackage

// File: rtl/cmp_shift_sel.sv
module cmp_shift_sel
  import dbuf_cmp_pkg::*;
(
  input  logic      buf_en,
  input  cmp_mode_e mode,
  input  logic      ovf_pulse,
  input  logic      start_pulse,
  output logic      shift
);
  always_comb begin
    shift = 1'b0;
    if (buf_en) begin
      unique case (mode)
        MODE_PWM: shift = ovf_pulse;
        MODE_PPG: shift = start_pulse;
        default:  shift = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cmp_reg_pair.sv
module cmp_reg_pair
  import dbuf_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         buf_en,
  input  logic         shift,
  input  cmp_mode_e    mode,
  input  logic         ovf_pulse,
  input  logic         start_pulse,
  output logic [W-1:0] active
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (wr_en) begin
      shadow_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (!buf_en && wr_en) begin
      active_q <= wr_data;
    end else if (shift) begin
      active_q <= shadow_q;
    end
  end

  assign active = active_q;

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && wr_en) |=> (active_q == $past(wr_data))); // R4

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !ovf_pulse && !start_pulse) |=> $stable(active_q)); // R5

  AST_PWM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && mode == MODE_PWM && ovf_pulse) |=> (active_q == $past(shadow_q))); // R6

  AST_PPG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && mode == MODE_PPG && start_pulse) |=> (active_q == $past(shadow_q))); // R7

  AST_TIMER_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && (mode == MODE_TIMER || mode == MODE_RSVD)) |=> $stable(active_q)); // R8

  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && wr_en) |=> (shadow_q == $past(wr_data))); // R10
endmodule

// File: rtl/cmp_match_det.sv
module cmp_match_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] active,
  input  logic [W-1:0] count,
  input  logic         ovf_pulse,
  output logic         match
);
  logic hit;
  logic match_q;

  always_comb begin
    if (active == '0) hit = ovf_pulse;
    else              hit = (count == active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= hit;
  end

  assign match = match_q;

  AST_MATCH_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (active != '0 && count == active) |=> match_q); // R2

  AST_NO_FALSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (active != '0 && count != active) |=> !match_q); // R2

  AST_ZERO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0 && ovf_pulse) |=> match_q); // R3

  AST_ZERO_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0 && !ovf_pulse) |=> !match_q); // R3
endmodule

// File: rtl/dbuf_cmp_stage.sv
module dbuf_cmp_stage
  import dbuf_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         buf_en,
  input  logic [1:0]   mode,
  input  logic [W-1:0] count,
  input  logic         ovf_pulse,
  input  logic         start_pulse,
  output logic         match_o,
  output logic [W-1:0] cmp_value_o
);
  cmp_mode_e    mode_e;
  logic         shift;
  logic [W-1:0] active;

  assign mode_e = cmp_mode_e'(mode);

  cmp_shift_sel u_shift (
    .buf_en     (buf_en),
    .mode       (mode_e),
    .ovf_pulse  (ovf_pulse),
    .start_pulse(start_pulse),
    .shift      (shift)
  );

  cmp_reg_pair #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .buf_en     (buf_en),
    .shift      (shift),
    .mode       (mode_e),
    .ovf_pulse  (ovf_pulse),
    .start_pulse(start_pulse),
    .active     (active)
  );

  cmp_match_det #(.W(W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .count    (count),
    .ovf_pulse(ovf_pulse),
    .match    (match_o)
  );

  assign cmp_value_o = active;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (cmp_value_o == '0 || $past(rst_n))); // R1
endmodule

// File: tb/test_dbuf_cmp_stage.sv
module test_dbuf_cmp_stage;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic       be = 1'b0;
  logic [1:0] md = 2'b00;
  logic [7:0] cnt = 8'h01;
  logic       ov = 1'b0;
  logic       st = 1'b0;
  logic       match_o;
  logic [7:0] cmp_value_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";

  logic [7:0] m_act = 8'h00;
  logic [7:0] m_sh = 8'h00;
  logic       m_match = 1'b0;

  always #5 clk = ~clk;

  dbuf_cmp_stage i_dbuf_cmp_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_data(wd), .buf_en(be),
    .mode(md), .count(cnt), .ovf_pulse(ov), .start_pulse(st),
    .match_o(match_o), .cmp_value_o(cmp_value_o)
  );

  // behavioural reference, one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 8'h00; m_sh = 8'h00; m_match = 1'b0;
    end else begin
      bit trig;
      logic [7:0] old_sh;
      trig = be && ((md == 2'd1 && ov) || (md == 2'd2 && st));
      old_sh = m_sh;
      m_match = (m_act == 8'h00) ? ov : (cnt == m_act);
      if (we) m_sh = wd;
      if (!be && we) m_act = wd;
      else if (trig) m_act = old_sh;
    end
  end

  task automatic compare();
    n_checks++;
    if (cmp_value_o !== m_act) begin
      n_fail++;
      $display("FAIL %s cmp_value_o actual=%02h expected=%02h", tag, cmp_value_o, m_act);
    end
    n_checks++;
    if (match_o !== m_match) begin
      n_fail++;
      $display("FAIL %s match_o actual=%0b expected=%0b", tag, match_o, m_match);
    end
  endtask

  task automatic step(input bit w, input logic [7:0] d, input bit b, input logic [1:0] m,
                      input logic [7:0] c, input bit o, input bit s);
    we = w; wd = d; be = b; md = m; cnt = c; ov = o; st = s;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; compare();           // R1 during reset
    rst_n = 1'b1;
    @(negedge clk); compare();       // R1 after release
    step(0, 8'h00, 0, 2'd0, 8'h05, 0, 0); // R1

    tag = "R4"; step(1, 8'h40, 0, 2'd0, 8'h01, 0, 0);
    tag = "R2";
    for (int i = 8'h3d; i <= 8'h43; i++) step(0, 8'h00, 0, 2'd0, i[7:0], 0, 0);
    step(0, 8'h00, 0, 2'd0, 8'h40, 1, 0);

    tag = "R3"; step(1, 8'h00, 0, 2'd0, 8'h10, 0, 0);
    step(0, 8'h00, 0, 2'd0, 8'h00, 0, 0);
    step(0, 8'h00, 0, 2'd0, 8'h00, 0, 0);
    step(0, 8'h00, 0, 2'd0, 8'hff, 1, 0);
    step(0, 8'h00, 0, 2'd0, 8'h00, 0, 0);

    tag = "R5"; step(1, 8'h80, 1, 2'd0, 8'h80, 0, 0);
    step(1, 8'h81, 1, 2'd1, 8'h81, 0, 0);
    step(0, 8'h00, 1, 2'd2, 8'h00, 0, 0);
    tag = "R8"; step(0, 8'h00, 1, 2'd0, 8'h00, 1, 1);
    step(0, 8'h00, 1, 2'd3, 8'h00, 1, 1);
    step(0, 8'h00, 1, 2'd3, 8'h00, 0, 1);
    tag = "R9"; step(0, 8'h00, 1, 2'd1, 8'h00, 0, 1);
    step(0, 8'h00, 1, 2'd2, 8'h00, 1, 0);
    tag = "R6"; step(0, 8'h00, 1, 2'd1, 8'h00, 1, 0);
    step(0, 8'h00, 1, 2'd1, 8'h81, 0, 0);
    step(0, 8'h00, 1, 2'd1, 8'h00, 0, 0);

    tag = "R7"; step(1, 8'h22, 1, 2'd2, 8'h00, 0, 0);
    step(0, 8'h00, 1, 2'd2, 8'h00, 0, 1);
    step(0, 8'h00, 1, 2'd2, 8'h22, 0, 0);

    tag = "R10"; step(1, 8'h33, 1, 2'd2, 8'h00, 0, 0);
    step(1, 8'h55, 1, 2'd2, 8'h00, 0, 1);
    step(0, 8'h00, 1, 2'd2, 8'h33, 0, 0);
    step(0, 8'h00, 1, 2'd2, 8'h00, 0, 1);
    step(1, 8'h66, 1, 2'd1, 8'h00, 1, 0);
    step(0, 8'h00, 1, 2'd1, 8'h00, 0, 0);

    tag = "R2";
    begin
      logic [15:0] lfsr = 16'hace1;
      for (int k = 0; k < 600; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] & lfsr[5], {lfsr[9:8], lfsr[3:1], 3'b000}, lfsr[4],
             lfsr[7:6], {lfsr[15:14], lfsr[11:9], 3'b000}, lfsr[12] & lfsr[2], lfsr[13]);
      end
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule